// File: doc/BRIEF.md
# Capture/Compare Channel with Toggle Output

This block is a single channel of a timer array. It keeps a 16-bit capture/compare register that software loads one byte at a time, and it watches a shared free-running counter that is generated outside the block. The channel can latch the counter value when its input pin changes. It can also compare the counter against its register and raise a flag, toggle an output pin on a full match, or produce a square wave by comparing only the low byte and then moving that byte forward by the high-byte offset.

Software selects the mode with five static control bits. A sixth state bit, the compare enable, sits inside the channel. A high-byte write sets it and a low-byte write clears it, so the comparator is off while a new 16-bit value is only half written. A capture or a match sets a sticky flag that software clears. When the interrupt enable is set, the flag drives a registered interrupt request. The counter source tells the channel, one cycle at a time, when the count has moved, and matches are only counted on those cycles.

Top module: `ccm_channel`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cc_value`, `cmp_en`, `flag`, `irq` and `out_pin` are all 0.
- R2: A `wr_lo` pulse loads `wr_data` into `cc_value[7:0]` and clears `cmp_en`. A `wr_hi` pulse loads `cc_value[15:8]` and sets `cmp_en`. Both take effect at the next clock edge. In the same cycle, a bus write to a byte overrides any hardware update of that byte.
- R3: Capture mode is active whenever `mode_pos` or `mode_neg` is 1. `mode_pos` selects rising edges of `cap_pin` and `mode_neg` selects falling edges; with both set, either edge captures. An edge of a polarity that is not selected leaves `cc_value` and `flag` unchanged.
- R4: After a change on `cap_pin`, `cc_value` takes the value of `cnt_val` at the third rising clock edge, not earlier, and `flag` is set at that same edge. This delay comes from a two-flop synchronizer followed by edge detection.
- R5: `flag` stays at 1 until a `flag_clr` pulse arrives. If a new capture or match coincides with `flag_clr`, the flag stays at 1. `irq` equals `flag & irq_en` and updates at the same edge as `flag`.
- R6: Software-timer mode is `mode_match`=1, `mode_toggle`=0, `mode_freq`=0, with `cmp_en`=1. A full 16-bit equality of `cnt_val` and `cc_value` sets `flag` and leaves `out_pin` unchanged. A match on the low byte alone does nothing.
- R7: High-speed output mode is `mode_match`=1, `mode_toggle`=1, `mode_freq`=0, with `cmp_en`=1. Each 16-bit match toggles `out_pin` and sets `flag`.
- R8: Frequency mode is `mode_toggle`=1, `mode_freq`=1, `mode_match`=0, with `cmp_en`=1. When `cnt_val[7:0]` equals `cc_value[7:0]`, `out_pin` toggles and `cc_value[7:0]` becomes `(cc_value[7:0] + cc_value[15:8]) mod 256`. `flag` is not set. A high byte of 0 therefore spaces the toggles 256 counts apart.
- R9: While `cmp_en` is 0, no compare mode toggles `out_pin` or sets `flag`.
- R10: A match is only evaluated in a cycle with `cnt_adv`=1. A counter that is held on the match value does not toggle the pin or set the flag again.
- R11: Capture mode takes priority over every compare bit, and compares do nothing while it is active. In any other mode-bit combination with no capture bit set, `out_pin` is left unchanged and `flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_adv | input | 1 | Counter took a new value this cycle |
| wr_lo | input | 1 | Write `wr_data` to the low register byte |
| wr_hi | input | 1 | Write `wr_data` to the high register byte |
| wr_data | input | 8 | Byte write data |
| mode_pos | input | 1 | Capture on rising pin edge |
| mode_neg | input | 1 | Capture on falling pin edge |
| mode_match | input | 1 | Match-enable mode bit |
| mode_toggle | input | 1 | Toggle mode bit |
| mode_freq | input | 1 | Frequency mode bit |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Software clear of the flag |
| cap_pin | input | 1 | Asynchronous capture input |
| cc_value | output | 16 | Capture/compare register |
| cmp_en | output | 1 | Comparator enable state |
| flag | output | 1 | Sticky capture/compare flag |
| irq | output | 1 | Interrupt request |
| out_pin | output | 1 | Toggle output |

## Verification
The bench builds the channel with the default parameters: a byte width of 8, which gives a 16-bit register, and two synchronizer stages. At these values, every low-byte wrap of the frequency-mode adder and the zero-offset case of 256 counts can be reached in a few writes. The three-edge capture latency can also be checked exactly, edge by edge. Random compare targets and offsets exercise the full 16-bit equality and the 8-bit modular addition against values the bench computes itself.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  typedef enum logic [2:0] {
    CCM_NONE = 3'd0,
    CCM_CAP  = 3'd1,
    CCM_SWT  = 3'd2,
    CCM_HSO  = 3'd3,
    CCM_FREQ = 3'd4
  } ccm_mode_e;
endpackage

// File: rtl/ccm_edge_sync.sv
module ccm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ccm_mode_dec.sv
module ccm_mode_dec
  import ccm_pkg::*;
(
  input  logic      pos,
  input  logic      neg,
  input  logic      match,
  input  logic      toggle,
  input  logic      freq,
  input  logic      cmp_en,
  output ccm_mode_e mode
);
  always_comb begin
    if (pos || neg)                       mode = CCM_CAP;
    else if (!cmp_en)                     mode = CCM_NONE;
    else if (match && !toggle && !freq)   mode = CCM_SWT;
    else if (match && toggle && !freq)    mode = CCM_HSO;
    else if (!match && toggle && freq)    mode = CCM_FREQ;
    else                                  mode = CCM_NONE;
  end
endmodule

// File: rtl/ccm_channel.sv
module ccm_channel
  import ccm_pkg::*;
#(
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*BW-1:0] cnt_val,
  input  logic            cnt_adv,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [BW-1:0]   wr_data,
  input  logic            mode_pos,
  input  logic            mode_neg,
  input  logic            mode_match,
  input  logic            mode_toggle,
  input  logic            mode_freq,
  input  logic            irq_en,
  input  logic            flag_clr,
  input  logic            cap_pin,
  output logic [2*BW-1:0] cc_value,
  output logic            cmp_en,
  output logic            flag,
  output logic            irq,
  output logic            out_pin
);
  localparam int CW = 2 * BW;

  logic [CW-1:0] cc_q, cc_d;
  logic          en_q, flag_q, irq_q, pin_q;
  logic          rise, fall;
  ccm_mode_e     mode_q;
  logic          hit16, hit_lo, cap_hit, set_flag, tog;

  ccm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (cap_pin),
    .rise(rise),
    .fall(fall)
  );

  ccm_mode_dec u_dec (
    .pos   (mode_pos),
    .neg   (mode_neg),
    .match (mode_match),
    .toggle(mode_toggle),
    .freq  (mode_freq),
    .cmp_en(en_q),
    .mode  (mode_q)
  );

  assign hit16    = cnt_adv && (cnt_val == cc_q);
  assign hit_lo   = cnt_adv && (cnt_val[BW-1:0] == cc_q[BW-1:0]);
  assign cap_hit  = (mode_q == CCM_CAP) &&
                    ((mode_pos && rise) || (mode_neg && fall));
  assign set_flag = cap_hit || (hit16 && (mode_q == CCM_SWT || mode_q == CCM_HSO));
  assign tog      = (hit16 && mode_q == CCM_HSO) || (hit_lo && mode_q == CCM_FREQ);

  always_comb begin
    cc_d = cc_q;
    if (cap_hit)
      cc_d = cnt_val;
    else if (hit_lo && mode_q == CCM_FREQ)
      cc_d[BW-1:0] = cc_q[BW-1:0] + cc_q[CW-1:BW];
    if (wr_lo) cc_d[BW-1:0]  = wr_data;
    if (wr_hi) cc_d[CW-1:BW] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q   <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      cc_q <= cc_d;
      if (wr_hi)      en_q <= 1'b1;
      else if (wr_lo) en_q <= 1'b0;
      flag_q <= set_flag || (flag_q && !flag_clr);
      irq_q  <= (set_flag || (flag_q && !flag_clr)) && irq_en;
      if (tog) pin_q <= ~pin_q;
    end
  end

  assign cc_value = cc_q;
  assign cmp_en   = en_q;
  assign flag     = flag_q;
  assign irq      = irq_q;
  assign out_pin  = pin_q;

  // R2
  hi_write_enables_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> cmp_en);
  // R2
  lo_write_disables_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> !cmp_en);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
  // R10
  stalled_counter_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_adv |=> $stable(out_pin));
  // R9
  comparator_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> $stable(out_pin));
  // R11
  capture_no_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_pos || mode_neg) |=> $stable(out_pin));
  // R8
  freq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_pos && !mode_neg && !mode_match && mode_toggle && mode_freq && cmp_en &&
     cnt_adv && cnt_val[BW-1:0] == cc_value[BW-1:0] && !wr_lo && !wr_hi)
    |=> cc_value[BW-1:0] == $past(BW'(cc_value[BW-1:0] + cc_value[CW-1:BW])));
endmodule

// File: tb/ccm_channel_tb_top.sv
module ccm_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = '0;
  logic        cnt_adv = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        mode_pos = 0, mode_neg = 0, mode_match = 0, mode_toggle = 0, mode_freq = 0;
  logic        irq_en = 0, flag_clr = 0, cap_pin = 0;
  logic [15:0] cc_value;
  logic        cmp_en, flag, irq, out_pin;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  logic exp_out = 1'b0;

  always #10 clk = ~clk;

  ccm_channel dut_i (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_adv(cnt_adv),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .mode_pos(mode_pos), .mode_neg(mode_neg), .mode_match(mode_match),
    .mode_toggle(mode_toggle), .mode_freq(mode_freq), .irq_en(irq_en),
    .flag_clr(flag_clr), .cap_pin(cap_pin), .cc_value(cc_value),
    .cmp_en(cmp_en), .flag(flag), .irq(irq), .out_pin(out_pin)
  );

  function automatic logic [7:0] freq_next(input logic [7:0] lo, input logic [7:0] off);
    return 8'((16'(lo) + 16'(off)) % 256);
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic p, input logic n, input logic m, input logic t, input logic f);
    mode_pos = p; mode_neg = n; mode_match = m; mode_toggle = t; mode_freq = f;
  endtask

  task automatic write16(input logic [15:0] v);
    wr_lo = 1; wr_data = v[7:0]; tick();
    wr_lo = 0; wr_hi = 1; wr_data = v[15:8]; tick();
    wr_hi = 0;
  endtask

  task automatic adv(input logic [15:0] v);
    cnt_val = v; cnt_adv = 1; tick();
    cnt_adv = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    tick(3);
    // R1 reset values while in reset and right after release
    check("R1 cc", 32'(cc_value), 0);
    rst = 0; tick();
    check("R1 cmp_en", 32'(cmp_en), 0);
    check("R1 flag", 32'(flag), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 out", 32'(out_pin), 0);

    // R2 byte writes
    wr_lo = 1; wr_data = 8'h34; tick(); wr_lo = 0;
    check("R2 lo byte", 32'(cc_value), 32'h0034);
    check("R2 lo clears en", 32'(cmp_en), 0);
    wr_hi = 1; wr_data = 8'h12; tick(); wr_hi = 0;
    check("R2 hi byte", 32'(cc_value), 32'h1234);
    check("R2 hi sets en", 32'(cmp_en), 1);
    wr_lo = 1; wr_data = 8'h99; tick(); wr_lo = 0;
    check("R2 lo again", 32'(cc_value), 32'h1299);
    check("R2 en cleared", 32'(cmp_en), 0);
    write16(16'h1234);

    // R6 software timer
    set_mode(0, 0, 1, 0, 0); irq_en = 1;
    adv(16'h1233);
    check("R6 no match", 32'(flag), 0);
    adv(16'h1234);
    check("R6 match flag", 32'(flag), 1);
    check("R5 irq", 32'(irq), 1);
    check("R6 pin unchanged", 32'(out_pin), 0);
    tick(3);
    check("R5 sticky", 32'(flag), 1);
    clear_flag();
    check("R5 cleared", 32'(flag), 0);
    check("R5 irq cleared", 32'(irq), 0);
    adv(16'h0034);
    check("R6 low byte only", 32'(flag), 0);

    // R10 and R7 high-speed output
    set_mode(0, 0, 1, 1, 0);
    cnt_val = 16'h1234; cnt_adv = 0; tick(3);
    check("R10 no adv pin", 32'(out_pin), 0);
    check("R10 no adv flag", 32'(flag), 0);
    adv(16'h1234); exp_out = ~exp_out;
    check("R7 toggle", 32'(out_pin), 32'(exp_out));
    check("R7 flag", 32'(flag), 1);
    tick(3);
    check("R10 held count", 32'(out_pin), 32'(exp_out));

    // R5 set wins over clear
    flag_clr = 1; adv(16'h1234); flag_clr = 0; exp_out = ~exp_out;
    check("R5 set beats clear", 32'(flag), 1);
    check("R7 toggle back", 32'(out_pin), 32'(exp_out));
    clear_flag();
    irq_en = 0;
    adv(16'h1234); exp_out = ~exp_out;
    check("R5 irq masked", 32'(irq), 0);
    check("R5 flag when masked", 32'(flag), 1);
    irq_en = 1; tick();
    check("R5 irq follows enable", 32'(irq), 1);
    clear_flag();

    // R9 comparator off after low-byte write
    wr_lo = 1; wr_data = 8'h34; tick(); wr_lo = 0;
    adv(16'h1234);
    check("R9 pin", 32'(out_pin), 32'(exp_out));
    check("R9 flag", 32'(flag), 0);
    wr_hi = 1; wr_data = 8'h12; tick(); wr_hi = 0;

    // R11 undefined combinations
    set_mode(0, 0, 0, 1, 0); adv(16'h1234);
    check("R11 toggle only pin", 32'(out_pin), 32'(exp_out));
    check("R11 toggle only flag", 32'(flag), 0);
    set_mode(0, 0, 1, 0, 1); adv(16'h1234);
    check("R11 match+freq pin", 32'(out_pin), 32'(exp_out));
    set_mode(0, 0, 1, 1, 1); adv(16'h1234);
    check("R11 all bits pin", 32'(out_pin), 32'(exp_out));
    check("R11 all bits flag", 32'(flag), 0);

    // R8 frequency output
    set_mode(0, 0, 0, 1, 1);
    write16(16'h1010);
    adv(16'h5510); exp_out = ~exp_out;
    check("R8 toggle", 32'(out_pin), 32'(exp_out));
    check("R8 step", 32'(cc_value), 32'h1020);
    check("R8 no flag", 32'(flag), 0);
    adv(16'h0025);
    check("R8 no match", 32'(cc_value), 32'h1020);
    adv(16'hFF20); exp_out = ~exp_out;
    check("R8 second step", 32'(cc_value), 32'h1030);
    write16(16'h0040);
    adv(16'h0040); exp_out = ~exp_out;
    check("R8 zero offset", 32'(cc_value), 32'h0040);
    check("R8 zero offset pin", 32'(out_pin), 32'(exp_out));
    for (int i = 0; i < 12; i++) begin
      logic [7:0] lo, off;
      lo = 8'($urandom); off = 8'($urandom);
      write16({off, lo});
      adv({8'($urandom), lo}); exp_out = ~exp_out;
      check("R8 random step", 32'(cc_value), 32'({off, freq_next(lo, off)}));
      check("R8 random pin", 32'(out_pin), 32'(exp_out));
    end

    // R2 bus write overrides hardware update
    write16(16'h0808);
    wr_lo = 1; wr_data = 8'h77; cnt_val = 16'h0008; cnt_adv = 1; tick();
    wr_lo = 0; cnt_adv = 0; exp_out = ~exp_out;
    check("R2 write wins", 32'(cc_value), 32'h0877);
    check("R2 write clears en", 32'(cmp_en), 0);
    check("R8 toggle on write cycle", 32'(out_pin), 32'(exp_out));

    // R3/R4 capture
    set_mode(1, 0, 0, 0, 0);
    cnt_val = 16'hABCD;
    cap_pin = 1; tick(2);
    check("R4 not yet", 32'(cc_value), 32'h0877);
    check("R4 no early flag", 32'(flag), 0);
    tick();
    check("R4 captured", 32'(cc_value), 32'hABCD);
    check("R4 flag", 32'(flag), 1);
    clear_flag();
    cnt_val = 16'h1111; cap_pin = 0; tick(4);
    check("R3 fall ignored", 32'(cc_value), 32'hABCD);
    check("R3 fall no flag", 32'(flag), 0);
    set_mode(0, 1, 0, 0, 0);
    cnt_val = 16'h2222; cap_pin = 1; tick(4);
    check("R3 rise ignored", 32'(cc_value), 32'hABCD);
    cap_pin = 0; tick(4);
    check("R3 falling capture", 32'(cc_value), 32'h2222);
    clear_flag();
    set_mode(1, 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] cv;
      cv = 16'($urandom);
      cnt_val = cv; cap_pin = ~cap_pin; tick(4);
      check("R3 either edge", 32'(cc_value), 32'(cv));
      check("R4 capture flag", 32'(flag), 1);
      clear_flag();
    end

    // R11 capture priority over compare bits
    write16(16'h4242);
    set_mode(1, 0, 1, 1, 0);
    adv(16'h4242);
    check("R11 capture priority pin", 32'(out_pin), 32'(exp_out));
    check("R11 capture priority flag", 32'(flag), 0);

    // R7 random high-speed targets
    set_mode(0, 0, 1, 1, 0);
    for (int i = 0; i < 12; i++) begin
      logic [15:0] t;
      t = 16'($urandom);
      write16(t);
      adv(t ^ 16'h0100);
      check("R7 random miss", 32'(out_pin), 32'(exp_out));
      adv(t); exp_out = ~exp_out;
      check("R7 random hit", 32'(out_pin), 32'(exp_out));
      check("R7 random flag", 32'(flag), 1);
      clear_flag();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule